// File: doc/BRIEF.md
# Codec Sample FIFO Status Controller

This block sits between a sigma-delta codec datapath and a host register bus. It holds two sample queues. The receive queue is filled by the converter side and drained by the host. The transmit queue is filled by the host and drained by the converter side. An 8-bit status word reports the state of both queues. A 4-bit enable word chooses which status conditions drive the single interrupt line.

A programmable level N sets when each direction asks for service. The receive side asks once enough samples have built up. The transmit side asks while its queue runs short. Misuse of either queue raises a per-direction error flag, and saturation pulses from the external filter, gain and modulator logic are held in sticky flags. Those pulses are only inputs here; the filters, gain stage and modulators sit outside the block. The host clears each sticky flag by writing a 1 to its bit position.

Top module: `codec_fifo_ctrl`

## Requirements
- R1: After reset, the status word, the interrupt enable word, the level N and the control word all read 0, and `irq` is 0.
- R2: Each queue holds 16 samples of 16 bits and returns them first in, first out. Register map: address 0 = sample data (a read pops the receive queue, a write pushes the transmit queue), 1 = status, 2 = interrupt enable, 3 = level N, 4 = control (bit 0 enables receive, bit 1 enables transmit). The converter reads the head of the transmit queue on `tx_sample` and removes it with `tx_pop`.
- R3: Status bit 4 is 1 when the receive queue is not empty, and status bit 5 is 1 when the transmit queue is not empty.
- R4: Status bit 0 is 1 while receive is enabled and the receive queue holds N or more samples; otherwise it is 0.
- R5: Status bit 1 is 1 while transmit is enabled and the transmit queue holds fewer than N samples; otherwise it is 0.
- R6: While receive is enabled, a host read of an empty receive queue or a converter push into a full receive queue sets sticky status bit 2. An empty read returns 0, and a push into a full queue is discarded.
- R7: While transmit is enabled, a converter pop of an empty transmit queue or a host write to a full transmit queue sets sticky status bit 3. An empty pop presents 0, and a write to a full queue is dropped.
- R8: A pulse on `rx_sat_filt` or `rx_sat_gain` sets sticky status bit 6. A pulse on `tx_sat_filt` or `tx_sat_mod` sets sticky status bit 7.
- R9: A write to the status address clears each of bits 7, 6, 3 and 2 whose write-data bit is 1. The other status bits are unaffected. A new event in the same cycle wins over the clear.
- R10: Interrupt enable bits 3..0 match status bits 3..0, and bits 7..4 read 0. `irq` is the OR of the enabled status bits among bits 3..0.
- R11: While a direction is disabled, its error bit is not set and its service bit stays 0, although its queue still moves data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host write (with bus_sel) |
| bus_rd | input | 1 | Host read (with bus_sel) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for the addressed register |
| rx_push | input | 1 | Converter pushes a received sample |
| rx_sample | input | 16 | Received sample value |
| tx_pop | input | 1 | Converter removes the transmit head |
| tx_sample | output | 16 | Transmit queue head, 0 when empty |
| rx_sat_filt | input | 1 | Receive filter saturation pulse |
| rx_sat_gain | input | 1 | Receive gain saturation pulse |
| tx_sat_filt | input | 1 | Transmit filter saturation pulse |
| tx_sat_mod | input | 1 | Modulator saturation pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the host does not issue a read and a write in the same access. They also assume that an event pulse arriving in the same cycle as a status write is meant to win over the clear. The queue checks assume that a push and a pop at a full or empty queue follow the drop rules, so the count must stay unchanged. The stimulus drives each bus access as a single-cycle read or write, never both. It changes inputs only on the falling edge and separates every host access from converter activity, so each expected status word can be worked out from one event at a time.

// File: rtl/codec_fifo_pkg.sv
package codec_fifo_pkg;
    typedef enum logic [2:0] {
        ADR_DATA = 3'd0,
        ADR_STAT = 3'd1,
        ADR_MASK = 3'd2,
        ADR_THR  = 3'd3,
        ADR_CTL  = 3'd4
    } reg_addr_e;

    // status bit positions (host software decodes these)
    localparam int SB_RIRQ = 0;
    localparam int SB_TIRQ = 1;
    localparam int SB_RERR = 2;
    localparam int SB_TERR = 3;
    localparam int SB_RFNE = 4;
    localparam int SB_TFNE = 5;
    localparam int SB_RSAT = 6;
    localparam int SB_TSAT = 7;
endpackage

// File: rtl/codec_sample_fifo.sv
module codec_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = s_q.cnt;
    assign dout    = empty ? '0 : mem_q[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (do_push)
            s_d.wp = (s_q.wp == AW'(DEPTH-1)) ? '0 : s_q.wp + 1'b1;
        if (do_pop)
            s_d.rp = (s_q.rp == AW'(DEPTH-1)) ? '0 : s_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= din;
    end

    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));            // R6
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);                             // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));                                           // R2
endmodule

// File: rtl/codec_stat_regs.sv
module codec_stat_regs #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic             wr_mask,
    input  logic             wr_thr,
    input  logic             wr_ctl,
    input  logic [7:0]       wdata,
    input  logic             rx_err_ev,
    input  logic             tx_err_ev,
    input  logic             rx_sat_ev,
    input  logic             tx_sat_ev,
    output logic [3:0]       irq_en,
    output logic [THR_W-1:0] thr,
    output logic             rx_en,
    output logic             tx_en,
    output logic             rerr,
    output logic             terr,
    output logic             rsat,
    output logic             tsat
);
    import codec_fifo_pkg::*;

    typedef struct packed {
        logic [3:0]       irq_en;
        logic [THR_W-1:0] thr;
        logic             rx_en;
        logic             tx_en;
        logic             rerr;
        logic             terr;
        logic             rsat;
        logic             tsat;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_mask) r_d.irq_en = wdata[3:0];
        if (wr_thr)  r_d.thr    = wdata[THR_W-1:0];
        if (wr_ctl) begin
            r_d.rx_en = wdata[0];
            r_d.tx_en = wdata[1];
        end
        if (wr_stat) begin
            if (wdata[SB_RERR]) r_d.rerr = 1'b0;
            if (wdata[SB_TERR]) r_d.terr = 1'b0;
            if (wdata[SB_RSAT]) r_d.rsat = 1'b0;
            if (wdata[SB_TSAT]) r_d.tsat = 1'b0;
        end
        if (rx_err_ev) r_d.rerr = 1'b1;
        if (tx_err_ev) r_d.terr = 1'b1;
        if (rx_sat_ev) r_d.rsat = 1'b1;
        if (tx_sat_ev) r_d.tsat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_en = r_q.irq_en;
    assign thr    = r_q.thr;
    assign rx_en  = r_q.rx_en;
    assign tx_en  = r_q.tx_en;
    assign rerr   = r_q.rerr;
    assign terr   = r_q.terr;
    assign rsat   = r_q.rsat;
    assign tsat   = r_q.tsat;

    AST_RX_SAT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sat_ev |=> rsat);                                            // R8
    AST_TX_SAT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sat_ev |=> tsat);                                            // R8
    AST_RERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rerr && !(wr_stat && wdata[SB_RERR])) |=> rerr);               // R9
    AST_TERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (terr && !(wr_stat && wdata[SB_TERR])) |=> terr);               // R9
endmodule

// File: rtl/codec_fifo_ctrl.sv
module codec_fifo_ctrl #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [2:0]          bus_addr,
    input  logic [SAMPLE_W-1:0] bus_wdata,
    output logic [SAMPLE_W-1:0] bus_rdata,
    input  logic                rx_push,
    input  logic [SAMPLE_W-1:0] rx_sample,
    input  logic                tx_pop,
    output logic [SAMPLE_W-1:0] tx_sample,
    input  logic                rx_sat_filt,
    input  logic                rx_sat_gain,
    input  logic                tx_sat_filt,
    input  logic                tx_sat_mod,
    output logic                irq
);
    import codec_fifo_pkg::*;

    localparam int CW    = $clog2(DEPTH+1);
    localparam int THR_W = $clog2(DEPTH);

    logic              acc_wr, acc_rd;
    logic              host_pop, host_push;
    logic [SAMPLE_W-1:0] rx_head;
    logic [CW-1:0]     rx_cnt, tx_cnt;
    logic              rx_empty, rx_full, tx_empty, tx_full;
    logic [3:0]        irq_en;
    logic [THR_W-1:0]  thr;
    logic              rx_en, tx_en, rerr, terr, rsat, tsat;
    logic              rx_err_ev, tx_err_ev;
    logic              rirq, tirq;
    logic [7:0]        status;

    assign acc_wr    = bus_sel && bus_wr;
    assign acc_rd    = bus_sel && bus_rd;
    assign host_pop  = acc_rd && (reg_addr_e'(bus_addr) == ADR_DATA);
    assign host_push = acc_wr && (reg_addr_e'(bus_addr) == ADR_DATA);

    codec_sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_sample), .pop(host_pop),
        .dout(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    codec_sample_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(host_push), .din(bus_wdata), .pop(tx_pop),
        .dout(tx_sample), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    assign rx_err_ev = rx_en && ((host_pop && rx_empty) || (rx_push && rx_full));
    assign tx_err_ev = tx_en && ((tx_pop && tx_empty) || (host_push && tx_full));

    codec_stat_regs #(.THR_W(THR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stat(acc_wr && (reg_addr_e'(bus_addr) == ADR_STAT)),
        .wr_mask(acc_wr && (reg_addr_e'(bus_addr) == ADR_MASK)),
        .wr_thr (acc_wr && (reg_addr_e'(bus_addr) == ADR_THR)),
        .wr_ctl (acc_wr && (reg_addr_e'(bus_addr) == ADR_CTL)),
        .wdata(bus_wdata[7:0]),
        .rx_err_ev(rx_err_ev), .tx_err_ev(tx_err_ev),
        .rx_sat_ev(rx_sat_filt || rx_sat_gain),
        .tx_sat_ev(tx_sat_filt || tx_sat_mod),
        .irq_en(irq_en), .thr(thr), .rx_en(rx_en), .tx_en(tx_en),
        .rerr(rerr), .terr(terr), .rsat(rsat), .tsat(tsat)
    );

    assign rirq = rx_en && (rx_cnt >= CW'(thr));
    assign tirq = tx_en && (tx_cnt <  CW'(thr));

    always_comb begin
        status          = '0;
        status[SB_RIRQ] = rirq;
        status[SB_TIRQ] = tirq;
        status[SB_RERR] = rerr;
        status[SB_TERR] = terr;
        status[SB_RFNE] = !rx_empty;
        status[SB_TFNE] = !tx_empty;
        status[SB_RSAT] = rsat;
        status[SB_TSAT] = tsat;
    end

    assign irq = |(status[3:0] & irq_en);

    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            ADR_DATA: bus_rdata = rx_head;
            ADR_STAT: bus_rdata = SAMPLE_W'(status);
            ADR_MASK: bus_rdata = SAMPLE_W'(irq_en);
            ADR_THR:  bus_rdata = SAMPLE_W'(thr);
            ADR_CTL:  bus_rdata = SAMPLE_W'({tx_en, rx_en});
            default:  bus_rdata = '0;
        endcase
    end

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'd0) |-> !irq);                                     // R10
    AST_RX_OFF_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rerr && !(bus_sel && bus_wr)) |=> !rerr);           // R11
    AST_TX_OFF_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !terr && !(bus_sel && bus_wr)) |=> !terr);           // R11
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && rx_empty) |-> (bus_rdata == '0));                  // R6
endmodule

// File: tb/sim_codec_fifo_ctrl.sv
module sim_codec_fifo_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rx_push = 0;
    logic [15:0] rx_sample = '0;
    logic        tx_pop = 0;
    logic [15:0] tx_sample;
    logic        rx_sat_filt = 0, rx_sat_gain = 0, tx_sat_filt = 0, tx_sat_mod = 0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    codec_fifo_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_sample(rx_sample),
        .tx_pop(tx_pop), .tx_sample(tx_sample), .rx_sat_filt(rx_sat_filt),
        .rx_sat_gain(rx_sat_gain), .tx_sat_filt(tx_sat_filt),
        .tx_sat_mod(tx_sat_mod), .irq(irq)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic conv_push(logic [15:0] s);
        @(negedge clk);
        rx_push = 1; rx_sample = s;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic conv_pop(output logic [15:0] s);
        @(negedge clk);
        tx_pop = 1;
        #1 s = tx_sample;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic stat_is(string req, logic [15:0] exp);
        logic [15:0] v;
        bus_read(3'd1, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        stat_is("R1 status", 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);
        bus_read(3'd2, v); check("R1 enable word", v, 16'h0000);
        bus_read(3'd3, v); check("R1 level", v, 16'h0000);
        bus_read(3'd4, v); check("R1 control", v, 16'h0000);
    endtask

    task automatic t_rx_order();
        logic [15:0] v;
        bus_write(3'd4, 16'h0003);
        stat_is("R4 level zero", 16'h0001);
        conv_push(16'h1111); conv_push(16'h2222); conv_push(16'h3333);
        stat_is("R3 rx not empty", 16'h0011);
        bus_read(3'd0, v); check("R2 order 1", v, 16'h1111);
        bus_read(3'd0, v); check("R2 order 2", v, 16'h2222);
        bus_read(3'd0, v); check("R2 order 3", v, 16'h3333);
        stat_is("R3 rx empty again", 16'h0001);
    endtask

    task automatic t_rx_irq();
        logic [15:0] v;
        bus_write(3'd3, 16'h0004);
        for (int i = 0; i < 3; i++) conv_push(16'h0500 + 16'(i));
        stat_is("R4 below level", 16'h0012);
        conv_push(16'h0503);
        stat_is("R4 at level", 16'h0013);
        bus_read(3'd0, v);
        stat_is("R4 drops below", 16'h0012);
        for (int i = 0; i < 3; i++) bus_read(3'd0, v);
        stat_is("R4 drained", 16'h0002);
    endtask

    task automatic t_tx_irq();
        logic [15:0] v;
        bus_write(3'd3, 16'h0002);
        stat_is("R5 empty below level", 16'h0002);
        bus_write(3'd0, 16'hA001); bus_write(3'd0, 16'hA002);
        stat_is("R5 at level", 16'h0020);
        conv_pop(v); check("R2 tx head 1", v, 16'hA001);
        stat_is("R5 below level again", 16'h0022);
        conv_pop(v); check("R2 tx head 2", v, 16'hA002);
        stat_is("R3 tx empty", 16'h0002);
    endtask

    task automatic t_rx_err();
        logic [15:0] v;
        bus_read(3'd0, v); check("R6 empty read value", v, 16'h0000);
        stat_is("R6 empty read flag", 16'h0006);
        bus_write(3'd1, 16'h0004);
        stat_is("R9 clear rerr", 16'h0002);
        for (int i = 0; i < 17; i++) conv_push(16'h0100 + 16'(i));
        stat_is("R6 overrun flag", 16'h0017);
        for (int i = 0; i < 16; i++) begin
            bus_read(3'd0, v);
            check("R6 overrun content", v, 16'h0100 + 16'(i));
        end
        stat_is("R6 after drain", 16'h0006);
        bus_write(3'd1, 16'h0004);
    endtask

    task automatic t_tx_err();
        logic [15:0] v;
        conv_pop(v); check("R7 empty pop value", v, 16'h0000);
        stat_is("R7 underrun flag", 16'h000A);
        bus_write(3'd1, 16'h0008);
        stat_is("R9 clear terr", 16'h0002);
        for (int i = 0; i < 17; i++) bus_write(3'd0, 16'hB000 + 16'(i));
        stat_is("R7 host overfill flag", 16'h0028);
        for (int i = 0; i < 16; i++) begin
            conv_pop(v);
            check("R7 overfill content", v, 16'hB000 + 16'(i));
        end
        stat_is("R7 after drain", 16'h000A);
        bus_write(3'd1, 16'h0008);
    endtask

    task automatic t_sat();
        @(negedge clk); rx_sat_gain = 1; @(negedge clk); rx_sat_gain = 0;
        stat_is("R8 rx gain sat", 16'h0042);
        @(negedge clk); tx_sat_mod = 1; @(negedge clk); tx_sat_mod = 0;
        stat_is("R8 modulator sat", 16'h00C2);
        bus_write(3'd1, 16'h0033);
        stat_is("R9 non-sticky bits ignored", 16'h00C2);
        bus_write(3'd1, 16'h0040);
        stat_is("R9 clear rsat only", 16'h0082);
        bus_write(3'd1, 16'h0080);
        stat_is("R9 clear tsat", 16'h0002);
        @(negedge clk); rx_sat_filt = 1; tx_sat_filt = 1;
        @(negedge clk); rx_sat_filt = 0; tx_sat_filt = 0;
        stat_is("R8 filter sats", 16'h00C2);
        // event arriving with the clear wins
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'd1; bus_wdata = 16'h00C0; rx_sat_gain = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; rx_sat_gain = 0;
        stat_is("R9 set wins over clear", 16'h0042);
        bus_write(3'd1, 16'h0040);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        bus_read(3'd0, v);
        stat_is("R10 setup", 16'h0006);
        check("R10 all blocked", {15'b0, irq}, 16'h0000);
        bus_write(3'd2, 16'h0004);
        #1 check("R10 rerr enabled", {15'b0, irq}, 16'h0001);
        bus_write(3'd2, 16'h0002);
        #1 check("R10 tirq enabled", {15'b0, irq}, 16'h0001);
        bus_write(3'd2, 16'h0001);
        #1 check("R10 rirq idle", {15'b0, irq}, 16'h0000);
        bus_write(3'd2, 16'h00FF);
        bus_read(3'd2, v); check("R10 reserved bits", v, 16'h000F);
        bus_write(3'd2, 16'h0000);
        bus_write(3'd1, 16'h0004);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        bus_write(3'd4, 16'h0000);
        bus_read(3'd0, v);
        conv_pop(v);
        stat_is("R11 no errors when off", 16'h0000);
        for (int i = 0; i < 5; i++) conv_push(16'h0700 + 16'(i));
        stat_is("R11 no service when off", 16'h0010);
        bus_read(3'd0, v); check("R11 queue still moves", v, 16'h0700);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_rx_order();
        t_rx_irq();
        t_tx_irq();
        t_rx_err();
        t_tx_err();
        t_sat();
        t_mask();
        t_disabled();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule